// File: doc/BRIEF.md
# Buffer-Occupancy Clock Trim Controller

This block derives a local clock-rate correction from the fill level of a video elastic buffer, so that a receiver stays locked to a sender without relying on transmitted clock references. The buffer fill level arrives on each sample tick. The samples are averaged over fixed windows of a power-of-two length, so short bursts produce no correction. After each window, the average is compared with a high and a low threshold. The block then moves a signed frequency-trim word up or down by one fixed step. The trim word is held inside a hard limit on total deviation, and an external DPLL consumes it.

The controller also orders the start-up phases. First comes a calibration period of a fixed number of windows, during which the thresholds are settled outside the block. Next, the system time counter is seeded once from the first presentation stamp, minus a fixed offset. After that, tuning continues for as long as the block runs. PTS parsing, the DPLL itself and the choice of thresholds belong to the surrounding system.

Top module: `fill_trim_ctrl`

## Requirements
- R1: `avg_level` equals the sum of the last 2^WIN_LOG2 sampled fill levels, shifted right by WIN_LOG2. `avg_valid` pulses for one cycle, in the cycle after the edge that takes the window's last sample. `trim_word` changes only on the edge that follows an `avg_valid` cycle.
- R2: In the tuning phase, a window average strictly above `thr_high` raises `trim_word` by TRIM_STEP.
- R3: In the tuning phase, a window average strictly below `thr_low` lowers `trim_word` by TRIM_STEP. An average equal to either threshold, or lying between them, leaves `trim_word` unchanged.
- R4: `trim_word` never leaves the range −TRIM_MAX to +TRIM_MAX. A step that would cross a limit leaves the word at that limit, and it never wraps.
- R5: The first `pts_valid` after reset loads `stc_value` with `pts_value − STC_OFFSET`, taken modulo 2^TS_W. `stc_load` pulses high in the cycle after that `pts_valid`.
- R6: `phase` reads 0 during calibration, 1 while waiting for the first stamp, and 2 while tuning. Calibration ends with the CAL_WINDOWS-th window average. No trim change happens before `phase` is 2, and the window that ends calibration causes none.
- R7: Every `pts_valid` after the first is ignored: `stc_load` stays low and `stc_value` keeps its value.
- R8: `trim_saturated` is high exactly when `trim_word` equals +TRIM_MAX or −TRIM_MAX.
- R9: If a window average is both above `thr_high` and below `thr_low` (thresholds crossed), the raise takes priority.
- R10: After reset, `trim_word` is 0, `phase` is 0, and `trim_saturated`, `avg_valid` and `stc_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Take one fill-level sample this cycle |
| fill_level | input | FILL_W | Current buffer occupancy |
| thr_high | input | FILL_W | Average above this raises the trim |
| thr_low | input | FILL_W | Average below this lowers the trim |
| pts_valid | input | 1 | A presentation stamp is offered |
| pts_value | input | TS_W | Offered stamp |
| avg_level | output | FILL_W | Last window average |
| avg_valid | output | 1 | One-cycle pulse, new average ready |
| trim_word | output | TRIM_W | Signed frequency trim for the DPLL |
| trim_saturated | output | 1 | Trim sits at a limit |
| stc_load | output | 1 | One-cycle pulse, STC seed valid |
| stc_value | output | TS_W | STC seed value |
| phase | output | 2 | 0 calibrate, 1 wait for stamp, 2 tune |

## Verification
The bench builds the block with windows of four samples, two calibration windows, a step of one and a limit of five. With these values both clamp limits can be reached, and held, within a few dozen windows. The stamp offset of 9000 on a 33-bit counter lets a small first stamp show the modular wrap of the seed. Random windows, with fill values spread across the full range, test the floor of the averaging shift and the comparison on both sides of each threshold. Two reset runs exercise both orders: the stamp arriving before calibration ends, and calibration ending first.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
   typedef enum logic [1:0] {
      PH_CAL  = 2'd0,
      PH_WAIT = 2'd1,
      PH_TUNE = 2'd2
   } ftc_phase_e;
endpackage

// File: rtl/ftc_fill_avg.sv
module ftc_fill_avg #(
   parameter int FILL_W   = 10,
   parameter int WIN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic [FILL_W-1:0] fill_level,
   output logic [FILL_W-1:0] avg_level,
   output logic              avg_valid
);
   localparam int ACC_W = FILL_W + WIN_LOG2;

   generate
      if (WIN_LOG2 == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               avg_level <= '0;
               avg_valid <= 1'b0;
            end else begin
               avg_valid <= sample_tick;
               if (sample_tick) avg_level <= fill_level;
            end
         end
      end else begin : g_accum
         logic [ACC_W-1:0]    acc_q;
         logic [ACC_W-1:0]    acc_nx;
         logic [WIN_LOG2-1:0] cnt_q;

         assign acc_nx = acc_q + ACC_W'(fill_level);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q     <= '0;
               cnt_q     <= '0;
               avg_level <= '0;
               avg_valid <= 1'b0;
            end else begin
               avg_valid <= 1'b0;
               if (sample_tick) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (&cnt_q) begin
                     avg_level <= FILL_W'(acc_nx >> WIN_LOG2);
                     avg_valid <= 1'b1;
                     acc_q     <= '0;
                  end else begin
                     acc_q <= acc_nx;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ftc_trim_step.sv
module ftc_trim_step #(
   parameter int FILL_W    = 10,
   parameter int TRIM_W    = 8,
   parameter int TRIM_MAX  = 5,
   parameter int TRIM_STEP = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     adj_en,
   input  logic [FILL_W-1:0]        avg_level,
   input  logic [FILL_W-1:0]        thr_high,
   input  logic [FILL_W-1:0]        thr_low,
   output logic signed [TRIM_W-1:0] trim_word,
   output logic                     trim_saturated
);
   localparam int EXT_W = TRIM_W + 2;
   localparam logic signed [EXT_W-1:0] MAX_E  = EXT_W'(TRIM_MAX);
   localparam logic signed [EXT_W-1:0] MIN_E  = -MAX_E;
   localparam logic signed [EXT_W-1:0] STEP_E = EXT_W'(TRIM_STEP);
   localparam logic signed [TRIM_W-1:0] MAX_T = TRIM_W'(TRIM_MAX);
   localparam logic signed [TRIM_W-1:0] MIN_T = -MAX_T;

   logic signed [EXT_W-1:0]  cur_e, up_e, dn_e;
   logic signed [TRIM_W-1:0] trim_nx;

   assign cur_e = {{2{trim_word[TRIM_W-1]}}, trim_word};
   assign up_e  = cur_e + STEP_E;
   assign dn_e  = cur_e - STEP_E;

   always_comb begin
      trim_nx = trim_word;
      if (avg_level > thr_high) begin
         trim_nx = (up_e > MAX_E) ? MAX_T : up_e[TRIM_W-1:0];
      end else if (avg_level < thr_low) begin
         trim_nx = (dn_e < MIN_E) ? MIN_T : dn_e[TRIM_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trim_word <= '0;
      else if (adj_en) trim_word <= trim_nx;
   end

   assign trim_saturated = (trim_word == MAX_T) || (trim_word == MIN_T);
endmodule

// File: rtl/ftc_phase_seq.sv
module ftc_phase_seq
   import ftc_pkg::*;
#(
   parameter int             TS_W        = 33,
   parameter logic [TS_W-1:0] STC_OFFSET = TS_W'(9000),
   parameter int             CAL_WINDOWS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            avg_valid,
   input  logic            pts_valid,
   input  logic [TS_W-1:0] pts_value,
   output logic            stc_load,
   output logic [TS_W-1:0] stc_value,
   output ftc_phase_e      phase_q
);
   localparam int CNT_W = $clog2(CAL_WINDOWS + 1);

   logic [CNT_W-1:0] cal_cnt;
   logic             stc_loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_CAL;
         cal_cnt      <= '0;
         stc_loaded_q <= 1'b0;
         stc_value    <= '0;
         stc_load     <= 1'b0;
      end else begin
         stc_load <= 1'b0;
         if (pts_valid && !stc_loaded_q) begin
            stc_value    <= pts_value - STC_OFFSET;
            stc_load     <= 1'b1;
            stc_loaded_q <= 1'b1;
         end
         case (phase_q)
            PH_CAL: begin
               if (avg_valid) begin
                  if (cal_cnt == CNT_W'(CAL_WINDOWS - 1))
                     phase_q <= stc_loaded_q ? PH_TUNE : PH_WAIT;
                  else
                     cal_cnt <= cal_cnt + 1'b1;
               end
            end
            PH_WAIT: if (stc_loaded_q) phase_q <= PH_TUNE;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fill_trim_ctrl.sv
module fill_trim_ctrl
   import ftc_pkg::*;
#(
   parameter int             FILL_W      = 10,
   parameter int             WIN_LOG2    = 2,
   parameter int             TRIM_W      = 8,
   parameter int             TRIM_MAX    = 5,
   parameter int             TRIM_STEP   = 1,
   parameter int             CAL_WINDOWS = 2,
   parameter int             TS_W        = 33,
   parameter logic [TS_W-1:0] STC_OFFSET = TS_W'(9000)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_tick,
   input  logic [FILL_W-1:0]        fill_level,
   input  logic [FILL_W-1:0]        thr_high,
   input  logic [FILL_W-1:0]        thr_low,
   input  logic                     pts_valid,
   input  logic [TS_W-1:0]          pts_value,
   output logic [FILL_W-1:0]        avg_level,
   output logic                     avg_valid,
   output logic signed [TRIM_W-1:0] trim_word,
   output logic                     trim_saturated,
   output logic                     stc_load,
   output logic [TS_W-1:0]          stc_value,
   output logic [1:0]               phase
);
   generate
      if (TRIM_MAX <= 0 || TRIM_MAX >= 2 ** (TRIM_W - 1)) begin : g_bad_max
         $error("TRIM_MAX must be positive and fit in TRIM_W");
      end
      if (TRIM_STEP <= 0 || TRIM_STEP > TRIM_MAX) begin : g_bad_step
         $error("TRIM_STEP must lie in 1..TRIM_MAX");
      end
      if (CAL_WINDOWS < 1) begin : g_bad_cal
         $error("CAL_WINDOWS must be at least 1");
      end
      if (WIN_LOG2 < 0 || WIN_LOG2 > 16) begin : g_bad_win
         $error("WIN_LOG2 out of range");
      end
   endgenerate

   ftc_phase_e phase_st;

   ftc_fill_avg #(.FILL_W(FILL_W), .WIN_LOG2(WIN_LOG2)) u_avg (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .fill_level(fill_level), .avg_level(avg_level), .avg_valid(avg_valid)
   );

   ftc_phase_seq #(.TS_W(TS_W), .STC_OFFSET(STC_OFFSET),
                   .CAL_WINDOWS(CAL_WINDOWS)) u_seq (
      .clk(clk), .rst_n(rst_n), .avg_valid(avg_valid),
      .pts_valid(pts_valid), .pts_value(pts_value),
      .stc_load(stc_load), .stc_value(stc_value), .phase_q(phase_st)
   );

   ftc_trim_step #(.FILL_W(FILL_W), .TRIM_W(TRIM_W), .TRIM_MAX(TRIM_MAX),
                   .TRIM_STEP(TRIM_STEP)) u_trim (
      .clk(clk), .rst_n(rst_n),
      .adj_en(avg_valid && (phase_st == PH_TUNE)),
      .avg_level(avg_level), .thr_high(thr_high), .thr_low(thr_low),
      .trim_word(trim_word), .trim_saturated(trim_saturated)
   );

   assign phase = phase_st;
endmodule

// File: rtl/ftc_chk.sv
module ftc_chk #(
   parameter int             FILL_W     = 10,
   parameter int             TRIM_W     = 8,
   parameter int             TRIM_MAX   = 5,
   parameter int             TRIM_STEP  = 1,
   parameter int             TS_W       = 33,
   parameter logic [TS_W-1:0] STC_OFFSET = TS_W'(9000)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [FILL_W-1:0]        avg_level,
   input logic                     avg_valid,
   input logic [FILL_W-1:0]        thr_high,
   input logic                     pts_valid,
   input logic [TS_W-1:0]          pts_value,
   input logic signed [TRIM_W-1:0] trim_word,
   input logic                     stc_load,
   input logic [TS_W-1:0]          stc_value,
   input logic [1:0]               phase
);
   logic seen_load;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_load <= 1'b0;
      else if (stc_load) seen_load <= 1'b1;
   end

   AST_TRIM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !avg_valid |=> $stable(trim_word)); // R1
   AST_TRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      avg_valid |=> ((longint'(trim_word) - longint'($past(trim_word)) <= TRIM_STEP) &&
                     (longint'($past(trim_word)) - longint'(trim_word) <= TRIM_STEP))); // R2
   AST_TRIM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_word <= TRIM_MAX) && (trim_word >= -TRIM_MAX)); // R4
   AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_word == TRIM_MAX && avg_valid && avg_level > thr_high) |=> trim_word == TRIM_MAX); // R4
   AST_STC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      stc_load |-> stc_value == $past(pts_value) - STC_OFFSET); // R5
   AST_NO_EARLY_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 2'd2) |=> $stable(trim_word)); // R6
   AST_STC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      seen_load |-> !stc_load); // R7
endmodule

bind fill_trim_ctrl ftc_chk #(
   .FILL_W(FILL_W), .TRIM_W(TRIM_W), .TRIM_MAX(TRIM_MAX),
   .TRIM_STEP(TRIM_STEP), .TS_W(TS_W), .STC_OFFSET(STC_OFFSET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .avg_level(avg_level), .avg_valid(avg_valid),
   .thr_high(thr_high), .pts_valid(pts_valid), .pts_value(pts_value),
   .trim_word(trim_word), .stc_load(stc_load), .stc_value(stc_value),
   .phase(phase)
);

// File: tb/fill_trim_ctrl_tb_top.sv
module fill_trim_ctrl_tb_top;
   localparam int FILL_W = 10;
   localparam int WIN_LOG2 = 2;
   localparam int TRIM_W = 8;
   localparam int TRIM_MAX = 5;
   localparam int TRIM_STEP = 1;
   localparam int CAL_WINDOWS = 2;
   localparam int TS_W = 33;
   localparam logic [TS_W-1:0] OFFS = TS_W'(9000);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_tick = 1'b0;
   logic [FILL_W-1:0] fill_level = '0;
   logic [FILL_W-1:0] thr_high = FILL_W'(700);
   logic [FILL_W-1:0] thr_low = FILL_W'(300);
   logic pts_valid = 1'b0;
   logic [TS_W-1:0] pts_value = '0;
   logic [FILL_W-1:0] avg_level;
   logic avg_valid;
   logic signed [TRIM_W-1:0] trim_word;
   logic trim_saturated;
   logic stc_load;
   logic [TS_W-1:0] stc_value;
   logic [1:0] phase;

   int total = 0;
   int bad = 0;
   int exp_trim = 0;
   int win_cnt = 0;
   bit stc_m = 0;
   bit tuned_m = 0;
   logic [TS_W-1:0] exp_stc = '0;

   always #10 clk = ~clk;

   fill_trim_ctrl #(.FILL_W(FILL_W), .WIN_LOG2(WIN_LOG2), .TRIM_W(TRIM_W),
      .TRIM_MAX(TRIM_MAX), .TRIM_STEP(TRIM_STEP), .CAL_WINDOWS(CAL_WINDOWS),
      .TS_W(TS_W), .STC_OFFSET(OFFS)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
      .fill_level(fill_level), .thr_high(thr_high), .thr_low(thr_low),
      .pts_valid(pts_valid), .pts_value(pts_value), .avg_level(avg_level),
      .avg_valid(avg_valid), .trim_word(trim_word),
      .trim_saturated(trim_saturated), .stc_load(stc_load),
      .stc_value(stc_value), .phase(phase));

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_trim(input int cur, input int avg, input int hi, input int lo);
      int n = cur;
      if (avg > hi) n = (cur + TRIM_STEP > TRIM_MAX) ? TRIM_MAX : cur + TRIM_STEP;
      else if (avg < lo) n = (cur - TRIM_STEP < -TRIM_MAX) ? -TRIM_MAX : cur - TRIM_STEP;
      return n;
   endfunction

   function automatic int exp_phase();
      if (win_cnt < CAL_WINDOWS) return 0;
      return tuned_m ? 2 : 1;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_trim = 0; win_cnt = 0; stc_m = 0; tuned_m = 0;
      @(negedge clk);
   endtask

   task automatic window(input int v0, input int v1, input int v2, input int v3,
                         input string req);
      int vals[4];
      int sum;
      int avg;
      vals = '{v0, v1, v2, v3};
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         sample_tick = 1'b1;
         fill_level = FILL_W'(vals[i]);
         sum += vals[i];
         @(negedge clk);
         sample_tick = 1'b0;
         if (i < 3) @(negedge clk);
      end
      avg = sum >> WIN_LOG2;
      check("R1 avg_valid", avg_valid, 1);
      check("R1 avg_level", avg_level, avg);
      if (tuned_m) exp_trim = next_trim(exp_trim, avg, int'(thr_high), int'(thr_low));
      win_cnt++;
      if (!tuned_m && win_cnt >= CAL_WINDOWS && stc_m) tuned_m = 1;
      @(negedge clk);
      check({req, " trim"}, trim_word, exp_trim);
      check("R8 saturated", trim_saturated,
            (exp_trim == TRIM_MAX || exp_trim == -TRIM_MAX) ? 1 : 0);
      check("R6 phase", phase, exp_phase());
   endtask

   task automatic send_pts(input logic [TS_W-1:0] v);
      pts_valid = 1'b1;
      pts_value = v;
      @(negedge clk);
      pts_valid = 1'b0;
      if (!stc_m) begin
         exp_stc = v - OFFS;
         check("R5 stc_load", stc_load, 1);
         check("R5 stc_value", stc_value, exp_stc);
         stc_m = 1;
         if (win_cnt >= CAL_WINDOWS) tuned_m = 1;
      end else begin
         check("R7 stc_load", stc_load, 0);
         check("R7 stc_value", stc_value, exp_stc);
      end
      @(negedge clk);
      @(negedge clk);
      check("R6 phase", phase, exp_phase());
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd17));
      do_reset();
      check("R10 trim", trim_word, 0);
      check("R10 phase", phase, 0);
      check("R10 saturated", trim_saturated, 0);
      check("R10 avg_valid", avg_valid, 0);
      check("R10 stc_load", stc_load, 0);

      // run A: calibration ends before any stamp
      window(900, 900, 900, 900, "R6");
      window(900, 900, 900, 900, "R6");
      check("R6 wait phase", phase, 1);
      window(900, 900, 900, 900, "R6 no tune while waiting");
      send_pts(TS_W'(20000));
      check("R6 tune phase", phase, 2);
      window(900, 900, 900, 900, "R2");

      // run B: stamp arrives during calibration, with wrap
      do_reset();
      window(1000, 1000, 1000, 1000, "R6");
      send_pts(TS_W'(100));
      send_pts(TS_W'(55555));
      window(1000, 1000, 1000, 1000, "R6 cal end");
      check("R6 tune phase", phase, 2);
      send_pts(TS_W'(77));

      window(700, 700, 700, 700, "R3 equal high");
      window(300, 300, 300, 300, "R3 equal low");
      window(1000, 0, 1000, 0, "R1 jitter mean");
      window(703, 700, 700, 700, "R1 floor");
      for (int k = 0; k < 7; k++) window(800, 850, 900, 950, "R4 up");
      check("R4 top", trim_word, TRIM_MAX);
      for (int k = 0; k < 12; k++) window(10, 20, 30, 40, "R4 down");
      check("R4 bottom", trim_word, -TRIM_MAX);
      for (int k = 0; k < 40; k++) begin
         window(int'($urandom_range(1023)), int'($urandom_range(1023)),
                int'($urandom_range(1023)), int'($urandom_range(1023)), "R2 R3 random");
      end
      thr_high = FILL_W'(200);
      thr_low = FILL_W'(800);
      window(500, 500, 500, 500, "R9 priority");
      window(500, 500, 500, 500, "R9 priority");
      thr_high = FILL_W'(700);
      thr_low = FILL_W'(300);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule